// File: doc/BRIEF.md
# Virtual interrupt flag controller

This block holds the interrupt-enable state of a processor core that can run legacy tasks under a supervisor. It keeps three bits: the real interrupt enable (IF), a shadow enable that the legacy task believes it controls (VIF), and a pending marker that only software writes (VIP). The decoder in front of the block gives it one-cycle strobes for the clear-enable, set-enable, push-flags and pop-flags instructions. A pop also carries the popped word.

The redirection is on when the core is in virtual mode and virtualization is enabled. In that state, clear, set and pop act on VIF, and a push reports VIF where the enable bit normally sits, so the task never touches IF. In every other state the same instructions act on IF. Acceptance of a maskable interrupt is decided only by IF. An accept pulse and the request's vector come out one cycle after the request.

All outputs are registered. Reset is synchronous and active high.

Top module: `vif_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no stimulus, `if_o`, `vif_o`, `vip_o`, `irq_take`, `push_valid` and `push_image` are all zero.
- R2: With `vm_mode` and `virt_en` both high, `op_cli` clears `vif_o` at the next clock edge and leaves `if_o` unchanged.
- R3: With `vm_mode` and `virt_en` both high, `op_sti` sets `vif_o` at the next clock edge and leaves `if_o` unchanged.
- R4: With `vm_mode` and `virt_en` both high, `op_popf` loads bit 9 of `pop_data` into `vif_o` at the next clock edge and leaves `if_o` unchanged. No other bit of `pop_data` has any effect.
- R5: `op_pushf` raises `push_valid` for exactly the next cycle. In that cycle `push_image` holds the flags from before the edge: bit 9 is VIF when virtualized and IF otherwise, bit 19 is VIF, bit 20 is VIP, and every other bit is zero.
- R6: When `vm_mode` or `virt_en` is low, clear, set and pop act on `if_o` in the same way (pop takes bit 9), and `vif_o` is unchanged.
- R7: When several of clear, set and pop are strobed in one cycle, only one of them acts, in the order clear first, then set, then pop.
- R8: `irq_take` is high in the cycle after `irq_req` was high while IF was set, and low otherwise, whatever the value of VIF. In the same cycle, `irq_take_vec` shows the request's vector for every value from 0 to 255.
- R9: `vip_o` takes `vip_wdata` at the edge where `vip_wr` is high and otherwise holds. No instruction strobe and no interrupt changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_cli | input | 1 | Clear-interrupt-enable instruction strobe |
| op_sti | input | 1 | Set-interrupt-enable instruction strobe |
| op_pushf | input | 1 | Push-flags instruction strobe |
| op_popf | input | 1 | Pop-flags instruction strobe |
| pop_data | input | 32 | Word popped by the pop-flags instruction |
| vm_mode | input | 1 | Core is running a legacy task in virtual mode |
| virt_en | input | 1 | Interrupt flag virtualization enabled |
| vip_wr | input | 1 | Software write strobe for the pending bit |
| vip_wdata | input | 1 | Value for the pending bit |
| irq_req | input | 1 | Maskable interrupt request |
| irq_vec | input | 8 | Vector of the request |
| if_o | output | 1 | Real interrupt enable |
| vif_o | output | 1 | Virtual interrupt enable |
| vip_o | output | 1 | Virtual interrupt pending |
| push_image | output | 32 | Flags word for the push, valid with push_valid |
| push_valid | output | 1 | push_image holds a push result |
| irq_take | output | 1 | Interrupt accepted |
| irq_take_vec | output | 8 | Vector of the accepted interrupt |

## Verification
The assertions expect the mode inputs `vm_mode` and `virt_en` to be sampled at the same edge as the strobe, so the bench drives every input half a cycle before the edge that uses it. They also expect reset to last at least one clock edge, and the bench holds it for several. The random stimulus toggles the mode bits freely and often fires two or three strobes in one cycle, so the priority order and the mode switches are covered. Directed cases add the extreme vectors and a request made while VIF and IF disagree.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic [1:0] {
    FOP_NONE = 2'd0,
    FOP_CLR  = 2'd1,
    FOP_SET  = 2'd2,
    FOP_LOAD = 2'd3
  } flag_op_e;

  typedef struct packed {
    logic if_f;
    logic vif_f;
    logic vip_f;
  } flag_state_t;
endpackage

// File: rtl/vif_op_decode.sv
module vif_op_decode
  import vif_pkg::*;
(
  input  logic     op_cli,
  input  logic     op_sti,
  input  logic     op_popf,
  input  logic     pop_bit,
  input  logic     vm_mode,
  input  logic     virt_en,
  output flag_op_e op,
  output logic     load_val,
  output logic     to_shadow
);
  always_comb begin
    to_shadow = vm_mode & virt_en;
    load_val  = 1'b0;
    // fixed priority: clear, then set, then pop (R7)
    if (op_cli) begin
      op = FOP_CLR;
    end else if (op_sti) begin
      op = FOP_SET;
    end else if (op_popf) begin
      op       = FOP_LOAD;
      load_val = pop_bit;
    end else begin
      op = FOP_NONE;
    end
  end
endmodule

// File: rtl/vif_flag_regs.sv
module vif_flag_regs
  import vif_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  flag_op_e    op,
  input  logic        load_val,
  input  logic        to_shadow,
  input  logic        vip_wr,
  input  logic        vip_wdata,
  output flag_state_t st
);
  flag_state_t st_q;
  logic        nxt_bit;
  logic        chk_arm_q;

  always_comb begin
    unique case (op)
      FOP_CLR:  nxt_bit = 1'b0;
      FOP_SET:  nxt_bit = 1'b1;
      FOP_LOAD: nxt_bit = load_val;
      default:  nxt_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (op != FOP_NONE) begin
        if (to_shadow) st_q.vif_f <= nxt_bit;
        else           st_q.if_f  <= nxt_bit;
      end
      if (vip_wr) st_q.vip_f <= vip_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chk_arm_q <= 1'b1;
  end

  assign st = st_q;

  a_r2_virt_keeps_if: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    (op != FOP_NONE && to_shadow) |=> $stable(st_q.if_f));
  a_r3_virt_set_vif: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    (op == FOP_SET && to_shadow) |=> st_q.vif_f);
  a_r6_direct_keeps_vif: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    (op != FOP_NONE && !to_shadow) |=> $stable(st_q.vif_f));
  a_r9_vip_holds: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    !vip_wr |=> $stable(st_q.vip_f));
  a_r9_vip_write: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    vip_wr |=> (st_q.vip_f == $past(vip_wdata)));
endmodule

// File: rtl/vif_push_image.sv
module vif_push_image
  import vif_pkg::*;
#(
  parameter int FLAG_W  = 32,
  parameter int IF_POS  = 9,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_pushf,
  input  logic              to_shadow,
  input  flag_state_t       st,
  output logic [FLAG_W-1:0] push_image,
  output logic              push_valid
);
  logic [FLAG_W-1:0] img_d;
  logic [FLAG_W-1:0] img_q;
  logic              valid_q;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (b == IF_POS) begin : g_if
      assign img_d[b] = to_shadow ? st.vif_f : st.if_f;
    end else if (b == VIF_POS) begin : g_vif
      assign img_d[b] = st.vif_f;
    end else if (b == VIP_POS) begin : g_vip
      assign img_d[b] = st.vip_f;
    end else begin : g_zero
      assign img_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      img_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= op_pushf;
      img_q   <= op_pushf ? img_d : '0;
    end
  end

  assign push_image = img_q;
  assign push_valid = valid_q;

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    op_pushf |=> push_valid);
  a_r5_image_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !op_pushf |=> (push_image == '0));
endmodule

// File: rtl/vif_irq_gate.sv
module vif_irq_gate #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             if_f,
  input  logic             vif_f,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_take_vec
);
  logic             take_q;
  logic [VEC_W-1:0] vec_q;
  logic             chk_arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= irq_req & if_f;
      vec_q  <= irq_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chk_arm_q <= 1'b1;
  end

  assign irq_take     = take_q;
  assign irq_take_vec = vec_q;

  a_r8_take_needs_if: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    irq_take |-> $past(if_f));
  a_r8_vif_irrelevant: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    (irq_req && if_f && !vif_f) |=> irq_take);
  a_r8_vec_follows: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
    irq_req |=> (irq_take_vec == $past(irq_vec)));
endmodule

// File: rtl/vif_ctrl.sv
module vif_ctrl
  import vif_pkg::*;
#(
  parameter int FLAG_W  = 32,
  parameter int IF_POS  = 9,
  parameter int VIF_POS = 19,
  parameter int VIP_POS = 20,
  parameter int VEC_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_cli,
  input  logic              op_sti,
  input  logic              op_pushf,
  input  logic              op_popf,
  input  logic [FLAG_W-1:0] pop_data,
  input  logic              vm_mode,
  input  logic              virt_en,
  input  logic              vip_wr,
  input  logic              vip_wdata,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              if_o,
  output logic              vif_o,
  output logic              vip_o,
  output logic [FLAG_W-1:0] push_image,
  output logic              push_valid,
  output logic              irq_take,
  output logic [VEC_W-1:0]  irq_take_vec
);
  flag_op_e    op;
  logic        load_val;
  logic        to_shadow;
  flag_state_t st;
  logic        unused_pop_rest;

  assign unused_pop_rest = ^pop_data;

  vif_op_decode u_dec (
    .op_cli    (op_cli),
    .op_sti    (op_sti),
    .op_popf   (op_popf),
    .pop_bit   (pop_data[IF_POS]),
    .vm_mode   (vm_mode),
    .virt_en   (virt_en),
    .op        (op),
    .load_val  (load_val),
    .to_shadow (to_shadow)
  );

  vif_flag_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .load_val  (load_val),
    .to_shadow (to_shadow),
    .vip_wr    (vip_wr),
    .vip_wdata (vip_wdata),
    .st        (st)
  );

  vif_push_image #(
    .FLAG_W (FLAG_W), .IF_POS (IF_POS), .VIF_POS (VIF_POS), .VIP_POS (VIP_POS)
  ) u_push (
    .clk        (clk),
    .rst        (rst),
    .op_pushf   (op_pushf),
    .to_shadow  (to_shadow),
    .st         (st),
    .push_image (push_image),
    .push_valid (push_valid)
  );

  vif_irq_gate #(.VEC_W (VEC_W)) u_irq (
    .clk          (clk),
    .rst          (rst),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec),
    .if_f         (st.if_f),
    .vif_f        (st.vif_f),
    .irq_take     (irq_take),
    .irq_take_vec (irq_take_vec)
  );

  assign if_o  = st.if_f;
  assign vif_o = st.vif_f;
  assign vip_o = st.vip_f;
endmodule

// File: tb/vif_ctrl_bench.sv
module vif_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_cli, op_sti, op_pushf, op_popf;
  logic [31:0] pop_data;
  logic        vm_mode, virt_en, vip_wr, vip_wdata, irq_req;
  logic [7:0]  irq_vec;
  logic        if_o, vif_o, vip_o, push_valid, irq_take;
  logic [31:0] push_image;
  logic [7:0]  irq_take_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic       e_if, e_vif, e_vip;

  always #5 clk = ~clk;

  vif_ctrl u_vif_ctrl (
    .clk (clk), .rst (rst), .op_cli (op_cli), .op_sti (op_sti),
    .op_pushf (op_pushf), .op_popf (op_popf), .pop_data (pop_data),
    .vm_mode (vm_mode), .virt_en (virt_en), .vip_wr (vip_wr),
    .vip_wdata (vip_wdata), .irq_req (irq_req), .irq_vec (irq_vec),
    .if_o (if_o), .vif_o (vif_o), .vip_o (vip_o), .push_image (push_image),
    .push_valid (push_valid), .irq_take (irq_take), .irq_take_vec (irq_take_vec)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_image(input logic sh, input logic fi, input logic fv, input logic fp);
    logic [31:0] w = '0;
    w[9]  = sh ? fv : fi;
    w[19] = fv;
    w[20] = fp;
    return w;
  endfunction

  task automatic step(input logic cli, input logic sti, input logic pushf, input logic popf,
                      input logic [31:0] pd, input logic vm, input logic en, input logic vw,
                      input logic vd, input logic irq, input logic [7:0] vec);
    logic sh, nb, any, take_e;
    logic [31:0] img_e;
    string tag;
    @(negedge clk);
    op_cli = cli; op_sti = sti; op_pushf = pushf; op_popf = popf; pop_data = pd;
    vm_mode = vm; virt_en = en; vip_wr = vw; vip_wdata = vd; irq_req = irq; irq_vec = vec;
    sh     = vm & en;
    any    = cli | sti | popf;
    nb     = cli ? 1'b0 : (sti ? 1'b1 : pd[9]);
    img_e  = pushf ? exp_image(sh, e_if, e_vif, e_vip) : 32'h0;
    take_e = irq & e_if;
    if (int'(cli) + int'(sti) + int'(popf) > 1) tag = "R7";
    else if (!any)  tag = "R9";
    else if (!sh)   tag = "R6";
    else if (cli)   tag = "R2";
    else if (sti)   tag = "R3";
    else            tag = "R4";
    if (any) begin
      if (sh) e_vif = nb;
      else    e_if  = nb;
    end
    if (vw) e_vip = vd;
    @(posedge clk);
    #1;
    check(if_o == e_if, {tag, " if"}, 32'(if_o), 32'(e_if));
    check(vif_o == e_vif, {tag, " vif"}, 32'(vif_o), 32'(e_vif));
    check(vip_o == e_vip, "R9 vip", 32'(vip_o), 32'(e_vip));
    check(irq_take == take_e, "R8 take", 32'(irq_take), 32'(take_e));
    if (irq) check(irq_take_vec == vec, "R8 vec", 32'(irq_take_vec), 32'(vec));
    check(push_valid == pushf, "R5 valid", 32'(push_valid), 32'(pushf));
    check(push_image == img_e, sh ? "R5 image" : "R6 image", push_image, img_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    op_cli = 0; op_sti = 0; op_pushf = 0; op_popf = 0; pop_data = '0;
    vm_mode = 0; virt_en = 0; vip_wr = 0; vip_wdata = 0; irq_req = 0; irq_vec = '0;
    repeat (4) @(posedge clk);
    #1;
    check({if_o, vif_o, vip_o, irq_take, push_valid} == 5'b0, "R1 flags in reset",
          32'({if_o, vif_o, vip_o, irq_take, push_valid}), 32'h0);
    check(push_image == 32'h0, "R1 image in reset", push_image, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    e_if = 0; e_vif = 0; e_vip = 0;
    step(0,0,0,0,'0,0,0,0,0,0,8'd0);
    check({if_o, vif_o, vip_o} == 3'b0, "R1 after release", 32'({if_o, vif_o, vip_o}), 32'h0);
    // R6: direct set, then R8 at both vector extremes
    step(0,1,0,0,'0,0,1,0,0,0,8'd0);
    step(0,0,0,0,'0,0,0,0,0,1,8'd0);
    step(0,0,0,0,'0,0,0,0,0,1,8'd255);
    // R2: virtualized clear leaves IF set, interrupt still taken (R8)
    step(1,0,0,0,'0,1,1,0,0,1,8'd77);
    step(0,0,1,0,'0,1,1,1,1,1,8'd200);
    // R4: pop with only bit 9 set and with all but bit 9
    step(0,0,0,1,32'h0000_0200,1,1,0,0,0,8'd0);
    step(0,0,1,1,32'hFFFF_FDFF,1,1,0,0,0,8'd0);
    // R7: all three strobes at once
    step(1,1,0,1,32'hFFFF_FFFF,1,1,0,0,0,8'd0);
    step(1,1,0,1,32'hFFFF_FFFF,0,1,0,0,1,8'd3);
    step(0,1,0,1,32'h0,1,0,0,0,1,8'd4);
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
           $urandom, ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 8) == 0,
           1'($urandom), ($urandom % 3) == 0, 8'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule